// File: doc/BRIEF.md
# Multi-Rail Power Sequencer with Fault Shutdown

The sequencer drives the enable inputs of six voltage regulators and watches the power-good signal that each one returns. After power-on reset it turns the rails on one at a time, starting with the highest voltage. It enables the next rail only when the current rail reports good. Each step has its own time limit. When a rail is late, or when any rail that is already enabled loses power-good, every enable goes low at once. The block then stays in a latched fault state until the next power-on reset.

Once all six rails are good, the sequencer keeps the board reset asserted for a programmable number of cycles and then releases it. The release also requires the 1.5 V rail, together with all other rails, to report good. Two other outputs serve software and the front panel. The first is an 8-bit status word that mirrors the raw power-good inputs. The second is a sticky early-failure flag, which marks that the 3.3 V rail was not good at the moment of shutdown.

Rail order, by bit index: bit 0 is 3.3 V, bit 1 is 2.5 V, bit 2 is 1.8 V, bit 3 is 1.5 V, bit 4 is 1.2 V and bit 5 is 1.05 V.

Top module: `pwr_seq_top`

## Requirements
- R1: While `por_n` is low, all enables are 0, `sys_rst_n_o` is 0 and `early_fail_o` is 0.
- R2: The enables rise one rail per step, in bit order 0 to 5, and always form a contiguous mask from bit 0. Rail k+1 is enabled on the clock edge that samples rail k's power-good high. The first rail is enabled on the first edge after `por_n` rises.
- R3: Counting the first cycle its enable is high as cycle 0, a rail must show power-good by cycle TMO_CYC-1. If it does not, all enables go low and the board is never released.
- R4: If the power-good of any rail that is already enabled and past its own step goes low, all enables are 0 from the next clock edge on.
- R5: A fault is latched. Enables stay 0 and `sys_rst_n_o` stays 0 whatever the power-good inputs do, until `por_n` is pulsed low.
- R6: `sys_rst_n_o` goes high exactly HOLD_CYC cycles after the edge that samples rail 5 good. It is high only while all six power-goods, including the 1.5 V rail (bit 3), are high. It drops in the same cycle as any power-good loss.
- R7: `pg_status_o` equals the live power-good inputs in bits 5..0, with bits 7..6 reading 0. No register sits in this path.
- R8: `early_fail_o` is set on entry to the fault state if rail 0's power-good is low on that edge. Once set, it stays set until `por_n` is pulsed low. A fault caused by any other rail leaves it at 0.
- R9: If a power-good arrives in the last permitted cycle of its step, the sequence advances. If a lower rail drops on the same edge that the current rail arrives, the fault takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; the only way out of a fault |
| pg_i | input | 6 | Power-good from each regulator, bit 0 = 3.3 V ... bit 5 = 1.05 V |
| en_o | output | 6 | Regulator enables, same bit order |
| sys_rst_n_o | output | 1 | Board reset, active low; released after sequencing and hold |
| pg_status_o | output | 8 | Live power-good mirror, upper two bits zero |
| early_fail_o | output | 1 | Sticky 3.3 V failure indicator |

## Verification
Two functions can fall in the same cycle: a rail's step advance and the fault detection. The timeout expiry can coincide with a late power-good. A lower rail can also drop on the very edge that the current rail reports good. The bench uses a delayed power-good model with per-rail delays. It sweeps each rail through delays of 0, 1, TMO_CYC-1 and TMO_CYC, so the last-cycle arrival collides with the expiring counter. A separate run forces rail 0 low on the edge where rail 2 arrives. Success is judged from the exact cycle of reset release. Fault is judged from zeroed enables, no release and the correct early-failure flag.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_RAMP,
        PS_HOLD,
        PS_RUN,
        PS_FAULT
    } pseq_state_e;

endpackage

// File: rtl/pwr_seq_cnt.sv
module pwr_seq_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int N_RAIL   = 6,
    parameter int CNT_W    = 4,
    parameter int TMO_CYC  = 4,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RAIL-1:0] pg_i,
    input  logic              zero_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic [N_RAIL-1:0] en_o,
    output logic              run_o,
    output logic              fault_o,
    output logic              early_fail_o
);

    localparam int SW = (N_RAIL > 1) ? $clog2(N_RAIL) : 1;
    localparam logic [SW-1:0]    LAST_STEP = SW'(N_RAIL - 1);
    localparam logic [CNT_W-1:0] TMO_LOAD  = CNT_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        pseq_state_e   state;
        logic [SW-1:0] step;
        logic          ef;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic [N_RAIL-1:0] en_mask, chk_mask;
    logic              checked_ok;

    always_comb begin
        en_mask  = '0;
        chk_mask = '0;
        for (int i = 0; i < N_RAIL; i++) begin
            unique case (cur_q.state)
                PS_RAMP: begin
                    en_mask[i]  = (i <= int'(cur_q.step));
                    chk_mask[i] = (i <  int'(cur_q.step));
                end
                PS_HOLD, PS_RUN: begin
                    en_mask[i]  = 1'b1;
                    chk_mask[i] = 1'b1;
                end
                default: begin
                    en_mask[i]  = 1'b0;
                    chk_mask[i] = 1'b0;
                end
            endcase
        end
        checked_ok = &(pg_i | ~chk_mask);

        nxt_d      = cur_q;
        load_o     = 1'b0;
        load_val_o = TMO_LOAD;

        unique case (cur_q.state)
            PS_IDLE: begin
                nxt_d.state = PS_RAMP;
                nxt_d.step  = '0;
                load_o      = 1'b1;
            end
            PS_RAMP: begin
                if (!checked_ok) begin
                    nxt_d.state = PS_FAULT;
                end else if (pg_i[cur_q.step]) begin
                    load_o = 1'b1;
                    if (cur_q.step == LAST_STEP) begin
                        nxt_d.state = PS_HOLD;
                        load_val_o  = HOLD_LOAD;
                    end else begin
                        nxt_d.step = cur_q.step + 1'b1;
                    end
                end else if (zero_i) begin
                    nxt_d.state = PS_FAULT;
                end
            end
            PS_HOLD: begin
                if (!checked_ok) begin
                    nxt_d.state = PS_FAULT;
                end else if (zero_i) begin
                    nxt_d.state = PS_RUN;
                end
            end
            PS_RUN: begin
                if (!checked_ok) begin
                    nxt_d.state = PS_FAULT;
                end
            end
            default: begin
                nxt_d.state = PS_FAULT;
            end
        endcase

        if (nxt_d.state == PS_FAULT && cur_q.state != PS_FAULT) begin
            nxt_d.ef = cur_q.ef | ~pg_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: PS_IDLE, step: '0, ef: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign en_o         = en_mask;
    assign run_o        = (cur_q.state == PS_RUN);
    assign fault_o      = (cur_q.state == PS_FAULT);
    assign early_fail_o = cur_q.ef;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
    parameter int N_RAIL   = 6,
    parameter int STAT_W   = 8,
    parameter int PG15_IDX = 3,
    parameter int TMO_CYC  = 4,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [N_RAIL-1:0] pg_i,
    output logic [N_RAIL-1:0] en_o,
    output logic              sys_rst_n_o,
    output logic [STAT_W-1:0] pg_status_o,
    output logic              early_fail_o
);

    localparam int MAXC  = (TMO_CYC > HOLD_CYC) ? TMO_CYC : HOLD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int PAD_W = STAT_W - N_RAIL;

    logic             load_w;
    logic [CNT_W-1:0] load_val_w;
    logic             zero_w;
    logic             run_w;
    logic             fault_w;

    pwr_seq_cnt #(.W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (por_n),
        .load_i     (load_w),
        .load_val_i (load_val_w),
        .zero_o     (zero_w)
    );

    pwr_seq_fsm #(
        .N_RAIL   (N_RAIL),
        .CNT_W    (CNT_W),
        .TMO_CYC  (TMO_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (por_n),
        .pg_i         (pg_i),
        .zero_i       (zero_w),
        .load_o       (load_w),
        .load_val_o   (load_val_w),
        .en_o         (en_o),
        .run_o        (run_w),
        .fault_o      (fault_w),
        .early_fail_o (early_fail_o)
    );

    // Release needs the run state plus every rail good, the 1.5 V rail included.
    assign sys_rst_n_o = run_w & (&pg_i) & pg_i[PG15_IDX];

    generate
        if (PAD_W > 0) begin : g_pad
            assign pg_status_o = {{PAD_W{1'b0}}, pg_i};
        end else begin : g_nopad
            assign pg_status_o = pg_i[STAT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int N_RAIL = 6
) (
    input logic              clk,
    input logic              por_n,
    input logic [N_RAIL-1:0] pg_i,
    input logic [N_RAIL-1:0] en_o,
    input logic              sys_rst_n_o,
    input logic              early_fail_o,
    input logic              fault_i
);

    AST_EN_PREFIX: assert property (@(posedge clk) disable iff (!por_n)
        ((en_o + 1'b1) & en_o) == '0); // R2

    AST_EN_ONE_STEP: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ($countones(en_o) <= $countones($past(en_o)) + 1)); // R2

    AST_RELEASE_ALL_GOOD: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_n_o |-> ((&en_o) && (&pg_i) && pg_i[3])); // R6

    AST_DROP_KILLS: assert property (@(posedge clk) disable iff (!por_n)
        ((&en_o) && !(&pg_i[N_RAIL-2:0])) |=> (en_o == '0)); // R4

    AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!por_n)
        fault_i |=> (fault_i && en_o == '0 && !sys_rst_n_o)); // R5

    AST_EARLY_FAIL_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        early_fail_o |=> early_fail_o); // R8

endmodule

bind pwr_seq_top pwr_seq_chk #(.N_RAIL(N_RAIL)) i_chk (
    .clk          (clk),
    .por_n        (por_n),
    .pg_i         (pg_i),
    .en_o         (en_o),
    .sys_rst_n_o  (sys_rst_n_o),
    .early_fail_o (early_fail_o),
    .fault_i      (fault_w)
);

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;

    localparam int NR   = 6;
    localparam int TMO  = 4;
    localparam int HOLD = 3;
    localparam int RUNL = 60;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic [NR-1:0] pg_i = '0;
    logic [NR-1:0] en_o;
    logic          sys_rst_n_o;
    logic [7:0]    pg_status_o;
    logic          early_fail_o;

    int nvec = 0;
    int nbad = 0;
    int dly [NR];
    int age [NR];
    logic [NR-1:0] f_lo = '0;
    logic [NR-1:0] f_hi = '0;
    int   drop_rail = -1;
    int   drop_idx  = -1;
    logic stat_ok;

    always #4 clk = ~clk;

    pwr_seq_top #(.TMO_CYC(TMO), .HOLD_CYC(HOLD)) i_pwr_seq_top (
        .clk          (clk),
        .por_n        (por_n),
        .pg_i         (pg_i),
        .en_o         (en_o),
        .sys_rst_n_o  (sys_rst_n_o),
        .pg_status_o  (pg_status_o),
        .early_fail_o (early_fail_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Regulator model: good one cycle after enable plus its delay, then forces.
    task automatic tick(input int idx);
        @(negedge clk);
        if (idx == drop_idx && drop_rail >= 0) f_lo[drop_rail] = 1'b1;
        for (int k = 0; k < NR; k++) begin
            age[k] = en_o[k] ? age[k] + 1 : 0;
            pg_i[k] = (en_o[k] && age[k] > dly[k] && !f_lo[k]) || f_hi[k];
        end
        #1;
        if (pg_status_o != {2'b00, pg_i}) stat_ok = 1'b0;
    endtask

    task automatic do_por();
        por_n = 1'b0;
        f_lo = '0; f_hi = '0; drop_rail = -1; drop_idx = -1;
        for (int k = 0; k < NR; k++) age[k] = 0;
        pg_i = '0;
        repeat (3) @(negedge clk);
        #1;
        check(en_o == '0 && sys_rst_n_o == 1'b0 && early_fail_o == 1'b0, "R1 reset state",
              int'({en_o, sys_rst_n_o, early_fail_o}), 0);
        @(negedge clk);
        por_n = 1'b1;
    endtask

    // Runs RUNL negedges; returns first release index (-1 if none) and prefix flag.
    task automatic run_seq(output int rel, output logic pre_ok);
        int entry [NR];
        int acc = 0;
        for (int k = 0; k < NR; k++) begin
            entry[k] = acc;
            acc += dly[k] + 1;
        end
        rel = -1;
        pre_ok = 1'b1;
        stat_ok = 1'b1;
        for (int n = 0; n < RUNL; n++) begin
            int cnt = 0;
            tick(n);
            for (int k = 0; k < NR; k++) if (entry[k] <= n) cnt++;
            if (en_o != NR'((1 << cnt) - 1)) pre_ok = 1'b0;
            if (sys_rst_n_o && rel < 0) rel = n;
        end
    endtask

    initial begin
        int rel;
        int s;
        logic pre_ok;
        int vals [4];
        vals[0] = 0; vals[1] = 1; vals[2] = TMO - 1; vals[3] = TMO;

        for (int k = 0; k < NR; k++) begin
            for (int vi = 0; vi < 4; vi++) begin
                int v = vals[vi];
                s = 0;
                for (int j = 0; j < NR; j++) begin
                    dly[j] = (j == k) ? v : (j + k) % 3;
                    s += dly[j] + 1;
                end
                do_por();
                run_seq(rel, pre_ok);
                check(stat_ok, "R7 status mirror", 0, 1);
                if (v < TMO) begin
                    int r = (k + v) % NR;
                    check(pre_ok, "R2 enable order", int'(en_o), 63);
                    // R9: v == TMO-1 is arrival in the last allowed cycle
                    check(rel == s + HOLD, "R6 R9 release cycle", rel, s + HOLD);
                    f_lo[r] = 1'b1;
                    tick(-2);
                    check(sys_rst_n_o == 1'b0, "R6 release drops with pg", int'(sys_rst_n_o), 0);
                    tick(-2);
                    check(en_o == '0, "R4 drop disables all", int'(en_o), 0);
                    check(early_fail_o == (r == 0), "R8 early fail flag",
                          int'(early_fail_o), int'(r == 0));
                    f_hi = '1;
                    repeat (5) tick(-2);
                    check(en_o == '0 && !sys_rst_n_o, "R5 fault latched", int'(en_o), 0);
                end else begin
                    check(rel == -1 && en_o == '0, "R3 timeout fault", rel, -1);
                    check(early_fail_o == (k == 0), "R8 early fail on timeout",
                          int'(early_fail_o), int'(k == 0));
                end
            end
        end

        // R9: lower rail drops on the edge where rail 2 arrives
        for (int j = 0; j < NR; j++) dly[j] = 0;
        dly[2] = 2;
        do_por();
        drop_rail = 0;
        drop_idx  = 1 + 1 + 2;
        run_seq(rel, pre_ok);
        check(rel == -1 && en_o == '0, "R9 fault wins over arrival", rel, -1);
        check(early_fail_o == 1'b1, "R9 R8 early fail set", int'(early_fail_o), 1);

        // R1 again after recovery by power-on reset
        do_por();
        check(en_o == '0, "R1 en before first edge", int'(en_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule